// File: doc/BRIEF.md
# Multi-Mode Triangular Array Processing Element

This block is one cell of a lower-triangular systolic array that runs an iterative semidefinite-relaxation detector. Each cell holds one entry of the current triangular factor, one accumulator for the product being formed and one register for the running column norm. A single shared multiplier and a single saturating adder serve all four operations. A mode input chooses between them, and an enable strobe marks the cycles on which the cell acts.

The array controller first loads the factor. It then runs one enabled multiply step per column of the product. Next it sweeps the squared norm down each column, and last it rescales the factor with a per-column value returned by the scale unit. The position of the cell fixes its variant through parameters: whether it sits on the diagonal, whether it lies in the bottom row, and which column it belongs to. Bottom-row cells work with one fewer fractional bit and hand their finished norm to the scale-unit port. All other cells pass it to the cell below.

Top module: `tri_pe`

## Requirements
- R1: After reset the stored factor value, the downward norm output and the scale-unit norm output are all zero.
- R2: An enabled step with mode code 0 (initialize) loads the column broadcast value into the stored factor of a diagonal cell and clears the stored factor of an off-diagonal cell to zero. The result is visible on `l_val` one cycle later.
- R3: An enabled step with mode code 1 (multiply) forms the product of its row operand and `col_bc`, shifted right arithmetically by 5 bits. On the first multiply step after any other enabled operation, or after reset, the accumulator becomes the stored factor minus that product. On each later step it becomes the accumulator minus that product.
- R4: On the multiply step whose zero-based index since entering multiply mode equals the cell's column parameter `COL`, the stored factor replaces `row_bc` as the row operand.
- R5: An enabled step with mode code 2 (norm) squares the accumulator and shifts the result right by the cell's fraction width. A diagonal cell registers that square as its norm. An off-diagonal cell registers `norm_in` plus that square.
- R6: An enabled step with mode code 3 (scale) stores `scale` times the accumulator, shifted right by the cell's fraction width, as the new factor value.
- R7: The fraction width is 8 bits for cells outside the bottom row and 7 bits for bottom-row cells. The multiplicand on `col_bc` in multiply mode carries 5 fractional bits.
- R8: Every product after its shift, and every sum or difference, is clamped to the signed 14-bit range [-8192, 8191] instead of wrapping.
- R9: A bottom-row cell drives its norm on `norm_to_scale` and holds `norm_out` at zero. Any other cell drives its norm on `norm_out` and holds `norm_to_scale` at zero.
- R10: With `en` low the stored factor, accumulator and norm keep their values, whatever the other inputs do.
- R11: Any enabled step in a mode other than multiply restarts the multiply step index at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Operation strobe; the cell acts only when high |
| mode | input | 2 | 0 initialize, 1 multiply, 2 norm, 3 scale |
| row_bc | input | 14 | Row broadcast factor entry (signed) |
| col_bc | input | 14 | Column broadcast: multiplicand entry in multiply mode, diagonal load value in initialize mode |
| norm_in | input | 14 | Partial squared norm from the cell above |
| scale | input | 14 | Column scale factor from the scale unit |
| norm_out | output | 14 | Partial squared norm to the cell below |
| norm_to_scale | output | 14 | Finished column norm to the scale unit (bottom row only) |
| l_val | output | 14 | Stored factor value |

## Verification
The hardest state to reach from the ports is the multiply step whose index matches the cell's column parameter while the accumulator already holds a value from earlier steps. The stimulus must sustain an unbroken run of enabled multiply steps, long enough to pass that index, without an intervening operation that restarts the count. The accumulator is not a port. It is brought out by a following norm step, or by a scale step with a unit factor, so each directed run ends with one of these. Random sequences weighted toward multiply, with enable gaps inserted, then also cross the index with idle cycles in between.

// File: rtl/tri_pe_pkg.sv
package tri_pe_pkg;
    localparam int PE_MODE_W = 2;

    typedef enum logic [PE_MODE_W-1:0] {
        PE_INIT  = 2'd0,
        PE_MUL   = 2'd1,
        PE_NORM  = 2'd2,
        PE_SCALE = 2'd3
    } pe_mode_e;
endpackage

// File: rtl/tri_pe_mulsat.sv
module tri_pe_mulsat #(
    parameter int W   = 14,
    parameter int SHW = 5
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic [SHW-1:0]      sh,
    output logic signed [W-1:0] y
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] HI = $signed({{(PW-W+1){1'b0}}, {(W-1){1'b1}}});
    localparam logic signed [PW-1:0] LO = ~HI;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = a * b;
        shifted = prod >>> sh;
        if (shifted > HI)      y = HI[W-1:0];
        else if (shifted < LO) y = LO[W-1:0];
        else                   y = shifted[W-1:0];
    end
endmodule

// File: rtl/tri_pe_addsat.sv
module tri_pe_addsat #(
    parameter int W = 14
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                sub,
    output logic signed [W-1:0] y
);
    logic signed [W:0] sum;

    always_comb begin
        if (sub) sum = {a[W-1], a} - {b[W-1], b};
        else     sum = {a[W-1], a} + {b[W-1], b};
        if (sum[W] != sum[W-1])
            y = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else
            y = sum[W-1:0];
    end
endmodule

// File: rtl/tri_pe.sv
module tri_pe
    import tri_pe_pkg::*;
#(
    parameter int W         = 14,
    parameter int FRAC      = 8,
    parameter int FRAC_LAST = 7,
    parameter int TFRAC     = 5,
    parameter bit IS_DIAG   = 1'b0,
    parameter bit LAST_ROW  = 1'b0,
    parameter int COL       = 0,
    parameter int MAX_CYC   = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [1:0]   mode,
    input  logic [W-1:0] row_bc,
    input  logic [W-1:0] col_bc,
    input  logic [W-1:0] norm_in,
    input  logic [W-1:0] scale,
    output logic [W-1:0] norm_out,
    output logic [W-1:0] norm_to_scale,
    output logic [W-1:0] l_val
);
    localparam int F     = LAST_ROW ? FRAC_LAST : FRAC;
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam int SHW   = $clog2(2 * W);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CYC);
    localparam logic [CNT_W-1:0] OWN_IDX = CNT_W'(COL);

    typedef struct packed {
        logic signed [W-1:0] lval;
        logic signed [W-1:0] acc;
        logic [CNT_W-1:0]    cnt;
        logic signed [W-1:0] norm;
    } pe_state_t;

    pe_state_t s_d, s_q;
    pe_mode_e  mode_e;

    logic signed [W-1:0] mul_a_d, mul_b_d, mul_y;
    logic signed [W-1:0] add_a_d, add_b_d, add_y;
    logic                add_sub_d;
    logic [SHW-1:0]      shamt_d;
    logic signed [W-1:0] init_val, norm_base;

    assign mode_e = pe_mode_e'(mode);

    // Diagonal and off-diagonal variants differ in load value and norm base
    generate
        if (IS_DIAG) begin : g_diag
            assign init_val  = col_bc;
            assign norm_base = '0;
        end else begin : g_offdiag
            assign init_val  = '0;
            assign norm_base = norm_in;
        end
    endgenerate

    tri_pe_mulsat #(.W(W), .SHW(SHW)) u_mul (
        .a (mul_a_d),
        .b (mul_b_d),
        .sh(shamt_d),
        .y (mul_y)
    );

    tri_pe_addsat #(.W(W)) u_add (
        .a  (add_a_d),
        .b  (add_b_d),
        .sub(add_sub_d),
        .y  (add_y)
    );

    // Operand steering for the shared multiplier and adder
    always_comb begin
        mul_a_d   = row_bc;
        mul_b_d   = col_bc;
        shamt_d   = SHW'(TFRAC);
        add_a_d   = s_q.acc;
        add_b_d   = mul_y;
        add_sub_d = 1'b1;
        case (mode_e)
            PE_MUL: begin
                mul_a_d = (s_q.cnt == OWN_IDX) ? s_q.lval : row_bc;
                add_a_d = (s_q.cnt == '0) ? s_q.lval : s_q.acc;
            end
            PE_NORM: begin
                mul_a_d   = s_q.acc;
                mul_b_d   = s_q.acc;
                shamt_d   = SHW'(F);
                add_a_d   = norm_base;
                add_sub_d = 1'b0;
            end
            PE_SCALE: begin
                mul_a_d = scale;
                mul_b_d = s_q.acc;
                shamt_d = SHW'(F);
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        s_d = s_q;
        if (en) begin
            case (mode_e)
                PE_INIT: begin
                    s_d.lval = init_val;
                    s_d.cnt  = '0;
                end
                PE_MUL: begin
                    s_d.acc = add_y;
                    if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
                end
                PE_NORM: begin
                    s_d.norm = add_y;
                    s_d.cnt  = '0;
                end
                PE_SCALE: begin
                    s_d.lval = mul_y;
                    s_d.cnt  = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign l_val = s_q.lval;

    generate
        if (LAST_ROW) begin : g_last
            assign norm_to_scale = s_q.norm;
            assign norm_out      = '0;
        end else begin : g_inner
            assign norm_to_scale = '0;
            assign norm_out      = s_q.norm;
        end
    endgenerate

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == PE_INIT) |=> (l_val == (IS_DIAG ? $past(col_bc) : '0))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(l_val) && $stable(s_q.acc) && $stable(s_q.norm))); // R10
    AST_MUL_KEEPS_FACTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == PE_MUL) |=> ($stable(l_val) && $stable(s_q.norm))); // R3
    AST_NORM_KEEPS_FACTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == PE_NORM) |=> ($stable(l_val) && $stable(s_q.acc))); // R5
    AST_SCALE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == PE_SCALE) |=> ($stable(s_q.acc) && $stable(s_q.norm))); // R6
    AST_INDEX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode != PE_MUL) |=> (s_q.cnt == '0)); // R11
endmodule

// File: tb/test_tri_pe.sv
module test_tri_pe;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [13:0] row_bc = '0, col_bc = '0, norm_in = '0, scale = '0;
    logic [13:0] no0, ns0, lv0, no1, ns1, lv1;

    int total = 0;
    int bad = 0;
    int seed_v;

    int mL[2], mAcc[2], mCnt[2], mNorm[2];
    int pDiag[2] = '{0, 1};
    int pCol[2]  = '{1, 2};
    int pF[2]    = '{8, 7};

    always #10 clk = ~clk;

    // inner off-diagonal cell in column 1
    tri_pe #(.IS_DIAG(1'b0), .LAST_ROW(1'b0), .COL(1)) i_tri_pe (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .row_bc(row_bc), .col_bc(col_bc), .norm_in(norm_in), .scale(scale),
        .norm_out(no0), .norm_to_scale(ns0), .l_val(lv0));

    // bottom-row diagonal cell in column 2
    tri_pe #(.IS_DIAG(1'b1), .LAST_ROW(1'b1), .COL(2)) i_tri_pe_last (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .row_bc(row_bc), .col_bc(col_bc), .norm_in(norm_in), .scale(scale),
        .norm_out(no1), .norm_to_scale(ns1), .l_val(lv1));

    function automatic int sat(input int v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic int msh(input int a, input int b, input int sh);
        int p;
        p = a * b;
        p = p >>> sh;
        return sat(p);
    endfunction

    function automatic int s14(input logic [13:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(s14(lv0) == mL[0], {tag, " l_val inner"}, s14(lv0), mL[0]);
        check(s14(lv1) == mL[1], {tag, " l_val last"}, s14(lv1), mL[1]);
        check(s14(no0) == mNorm[0], {tag, " R9 norm_out inner"}, s14(no0), mNorm[0]);
        check(s14(ns0) == 0, "R9 norm_to_scale inner zero", s14(ns0), 0);
        check(s14(ns1) == mNorm[1], {tag, " R9 norm_to_scale last"}, s14(ns1), mNorm[1]);
        check(s14(no1) == 0, "R9 norm_out last zero", s14(no1), 0);
    endtask

    // Drive at a falling edge, update the model at the rising edge, compare at the next falling edge
    task automatic step(input bit e, input int md, input int r, input int c,
                        input int n, input int s);
        string tag;
        en = e; mode = md[1:0];
        row_bc = r[13:0]; col_bc = c[13:0]; norm_in = n[13:0]; scale = s[13:0];
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            if (e) begin
                case (md)
                    0: begin mL[p] = pDiag[p] ? c : 0; mCnt[p] = 0; end
                    1: begin
                        int a, base;
                        a    = (mCnt[p] == pCol[p]) ? mL[p] : r;
                        base = (mCnt[p] == 0) ? mL[p] : mAcc[p];
                        mAcc[p] = sat(base - msh(a, c, 5));
                        if (mCnt[p] < 15) mCnt[p]++;
                    end
                    2: begin
                        mNorm[p] = sat((pDiag[p] ? 0 : n) + msh(mAcc[p], mAcc[p], pF[p]));
                        mCnt[p] = 0;
                    end
                    default: begin mL[p] = msh(s, mAcc[p], pF[p]); mCnt[p] = 0; end
                endcase
            end
        end
        @(negedge clk);
        if (!e)            tag = "R10";
        else if (md == 0)  tag = "R2";
        else if (md == 1)  tag = "R3 R4 R11";
        else if (md == 2)  tag = "R5 R7";
        else               tag = "R6 R7 R8";
        compare_all(tag);
    endtask

    function automatic int rnd14();
        return int'($urandom_range(0, 16383)) - 8192;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_v = int'($urandom(32'd20240611));
        for (int p = 0; p < 2; p++) begin
            mL[p] = 0; mAcc[p] = 0; mCnt[p] = 0; mNorm[p] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(s14(lv0) == 0 && s14(lv1) == 0, "R1 l_val after reset", s14(lv0) | s14(lv1), 0);
        check(no0 == 0 && ns1 == 0, "R1 norm after reset", s14(no0) | s14(ns1), 0);

        // R2: initialize, diagonal loads, off-diagonal clears
        step(1, 0, 0, 291, 0, 0);
        // R3 R4: multiply run crossing both column indices, then read back via norm and scale
        step(1, 1, 100, 64, 0, 0);
        step(1, 1, -200, 96, 0, 0);
        step(1, 1, 50, -32, 0, 0);
        step(1, 1, 7, 40, 0, 0);
        // R5: norm, off-diagonal adds norm_in
        step(1, 2, 0, 0, 1000, 0);
        // R10: idle with moving inputs
        step(0, 3, 1234, -999, 555, 4000);
        step(0, 0, 77, 88, 99, 11);
        // R6 R7: unit scale per fraction width (256 reads inner acc, 128 reads last acc)
        step(1, 3, 0, 0, 0, 256);
        step(1, 3, 0, 0, 0, 128);
        // R11: restart index after scale, then multiply again
        step(1, 1, 10, 32, 0, 0);
        step(1, 1, 20, 32, 0, 0);
        step(1, 1, 30, 32, 0, 0);
        step(1, 2, 0, 0, -50, 0);
        // R8: saturation corners
        step(1, 0, 0, 8191, 0, 0);
        step(1, 1, -8192, 8191, 0, 0);
        step(1, 3, 0, 0, 0, 8191);
        step(1, 2, 0, 0, 8191, 0);
        step(1, 0, 0, -8192, 0, 0);
        step(1, 1, 8191, 8191, 0, 0);
        step(1, 2, 0, 0, -8192, 0);

        // random mix, weighted toward multiply runs
        for (int i = 0; i < 600; i++) begin
            int md;
            int sel;
            sel = int'($urandom_range(0, 9));
            md  = (sel < 5) ? 1 : (sel < 7) ? 2 : (sel < 8) ? 3 : 0;
            step($urandom_range(0, 9) != 0, md, rnd14(), rnd14(), rnd14(), rnd14());
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule